// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns the single column address that arrives with a read or write command into the column address of every beat of the burst, one address per clock. The caller supplies the starting column, a one-cycle start strobe, a burst-length code and an order bit. From these the block walks the burst. The low column bits wrap inside a window aligned to the burst length, so a burst never crosses that window.

Two wrap orders are offered. The sequential order adds the beat number to the low start bits. The interleave order combines them with XOR. A full-page mode uses the sequential order only. It steps through every column of the page, wraps from the top column to column 0, and runs until it is terminated or restarted. A new start may arrive on any clock and replaces the burst in progress. Data transfer and read-latency delay belong to the surrounding controller.

Top module: `sdram_burst_colgen`

## Requirements
- R1: A synchronous active-high `rst` drives `valid_o`, `last_o` and `col_o` to 0 at the clock edge where it is sampled.
- R2: At the edge after one that samples `start_i`, `valid_o` is 1 and `col_o` equals the sampled `start_col_i`. This holds even when a burst is still running, which then ends.
- R3: `len_code_i` values 0, 1, 2 and 3 select bursts of 1, 2, 4 and 8 beats. `valid_o` stays high on exactly that many consecutive cycles and then goes low.
- R4: With `order_i` = 0 (sequential), beat n has the low log2(L) bits equal to (start + n) mod L. The upper bits are the start's upper bits.
- R5: With `order_i` = 1 (interleave), beat n has the low log2(L) bits equal to start XOR n. The upper bits are unchanged. For example, L = 8 starting at 2 gives 2,3,0,1,6,7,4,5 in the low bits.
- R6: In fixed-length bursts, `last_o` is high on the final beat only, and never while `valid_o` is low.
- R7: `len_code_i` = 7 with `order_i` = 0 selects full page. `col_o` rises by one every cycle, wraps from 2^COL_W-1 to 0, never ends by itself, and `last_o` stays 0.
- R8: `stop_i` sampled without `start_i` makes `valid_o` and `last_o` 0 at the next edge. When both are sampled together, `start_i` wins.
- R9: Reserved codes 4, 5 and 6 give a single-beat burst. So does code 7 with `order_i` = 1.
- R10: Starts on consecutive clocks each produce their own start column on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Strobe that loads a new burst |
| start_col_i | input | COL_W | Starting column address |
| len_code_i | input | 3 | Burst length: 0=1, 1=2, 2=4, 3=8, 7=full page |
| order_i | input | 1 | 0 sequential, 1 interleave |
| stop_i | input | 1 | Ends the running burst |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | Beat present on `col_o` |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
The order logic is tried with start columns whose low bits are zero, mid-window and at the top of the window. Zero-offset starts show a missing window base. Mid-window starts separate sequential addition from XOR. Top-of-window starts show whether the carry leaks into the upper bits. Starts near the top of the column range check that wrapping stays inside the window for fixed bursts and crosses to column 0 in full page. Restarts mid-burst, back-to-back starts, stop and start sampled together, and reserved codes exercise the control priority.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;
  localparam int unsigned LEN_CODE_W = 3;
  localparam logic [LEN_CODE_W-1:0] LEN_PAGE = 3'd7;

  typedef enum logic {
    ORDER_SEQ = 1'b0,
    ORDER_ILV = 1'b1
  } order_e;
endpackage

// File: rtl/burst_len_decode.sv
module burst_len_decode
  import sdram_burst_pkg::*;
#(
  parameter int unsigned COL_W    = 10,
  parameter int unsigned MAX_LOG2 = 3
) (
  input  logic [LEN_CODE_W-1:0] code_i,
  input  logic                  order_i,
  output logic [COL_W-1:0]      mask_o,
  output logic                  full_o
);
  logic [COL_W-1:0] fixed_mask [MAX_LOG2+1];

  genvar g;
  generate
    for (g = 0; g <= MAX_LOG2; g++) begin : g_mask
      assign fixed_mask[g] = COL_W'((1 << g) - 1);
    end
  endgenerate

  always_comb begin
    mask_o = '0;
    full_o = 1'b0;
    if (32'(code_i) <= MAX_LOG2) begin
      mask_o = fixed_mask[code_i];
    end else if (code_i == LEN_PAGE && order_i == ORDER_SEQ) begin
      mask_o = '1;
      full_o = 1'b1;
    end
  end
endmodule

// File: rtl/burst_addr_map.sv
module burst_addr_map #(
  parameter int unsigned COL_W = 10
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] addr_o
);
  logic [COL_W-1:0] sum;
  assign sum = base_i + beat_i;

  genvar b;
  generate
    for (b = 0; b < COL_W; b++) begin : g_bit
      assign addr_o[b] = mask_i[b] ? (ilv_i ? (base_i[b] ^ beat_i[b]) : sum[b])
                                   : base_i[b];
    end
  endgenerate
endmodule

// File: rtl/burst_beat_ctrl.sv
module burst_beat_ctrl #(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [COL_W-1:0] dec_mask_i,
  input  logic             dec_full_i,
  input  logic             dec_ilv_i,
  output logic [COL_W-1:0] map_base_o,
  output logic [COL_W-1:0] map_beat_o,
  output logic [COL_W-1:0] map_mask_o,
  output logic             map_ilv_o,
  output logic             nxt_valid_o,
  output logic             nxt_last_o
);
  logic [COL_W-1:0] base_q, beat_q, mask_q;
  logic             full_q, ilv_q, active_q;
  logic [COL_W-1:0] beat_inc;

  assign beat_inc = beat_q + 1'b1;

  always_comb begin
    map_base_o  = base_q;
    map_beat_o  = beat_inc;
    map_mask_o  = mask_q;
    map_ilv_o   = ilv_q;
    nxt_valid_o = 1'b0;
    nxt_last_o  = 1'b0;
    if (start_i) begin
      map_base_o  = start_col_i;
      map_beat_o  = '0;
      map_mask_o  = dec_mask_i;
      map_ilv_o   = dec_ilv_i;
      nxt_valid_o = 1'b1;
      nxt_last_o  = !dec_full_i && (dec_mask_i == '0);
    end else if (stop_i) begin
      nxt_valid_o = 1'b0;
    end else if (active_q) begin
      nxt_valid_o = 1'b1;
      nxt_last_o  = !full_q && (beat_inc == mask_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      beat_q   <= '0;
      mask_q   <= '0;
      full_q   <= 1'b0;
      ilv_q    <= 1'b0;
      active_q <= 1'b0;
    end else begin
      if (start_i) begin
        base_q <= start_col_i;
        mask_q <= dec_mask_i;
        full_q <= dec_full_i;
        ilv_q  <= dec_ilv_i;
      end
      if (nxt_valid_o) beat_q <= map_beat_o;
      active_q <= nxt_valid_o && !nxt_last_o;
    end
  end
endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import sdram_burst_pkg::*;
#(
  parameter int unsigned COL_W    = 10,
  parameter int unsigned MAX_LOG2 = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_i,
  input  logic [COL_W-1:0]      start_col_i,
  input  logic [LEN_CODE_W-1:0] len_code_i,
  input  logic                  order_i,
  input  logic                  stop_i,
  output logic [COL_W-1:0]      col_o,
  output logic                  valid_o,
  output logic                  last_o
);
  logic [COL_W-1:0] dec_mask, map_base, map_beat, map_mask, map_addr;
  logic             dec_full, map_ilv, nxt_valid, nxt_last;

  burst_len_decode #(.COL_W(COL_W), .MAX_LOG2(MAX_LOG2)) u_dec (
    .code_i (len_code_i),
    .order_i(order_i),
    .mask_o (dec_mask),
    .full_o (dec_full)
  );

  burst_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .stop_i     (stop_i),
    .start_col_i(start_col_i),
    .dec_mask_i (dec_mask),
    .dec_full_i (dec_full),
    .dec_ilv_i  (order_i == ORDER_ILV),
    .map_base_o (map_base),
    .map_beat_o (map_beat),
    .map_mask_o (map_mask),
    .map_ilv_o  (map_ilv),
    .nxt_valid_o(nxt_valid),
    .nxt_last_o (nxt_last)
  );

  burst_addr_map #(.COL_W(COL_W)) u_map (
    .base_i(map_base),
    .beat_i(map_beat),
    .mask_i(map_mask),
    .ilv_i (map_ilv),
    .addr_o(map_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      col_o   <= '0;
      valid_o <= 1'b0;
      last_o  <= 1'b0;
    end else begin
      valid_o <= nxt_valid;
      last_o  <= nxt_last;
      if (nxt_valid) col_o <= map_addr;
    end
  end
endmodule

// File: rtl/sdram_burst_colgen_chk.sv
module sdram_burst_colgen_chk #(
  parameter int unsigned COL_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [2:0]       len_code_i,
  input logic             order_i,
  input logic             stop_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);
  assert_start_load_R2: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (valid_o && col_o == $past(start_col_i)));

  assert_last_in_beat_R6: assert property (@(posedge clk) disable iff (rst)
    last_o |-> valid_o);

  assert_end_after_last_R3: assert property (@(posedge clk) disable iff (rst)
    (last_o && !start_i) |=> !valid_o);

  assert_page_no_last_R7: assert property (@(posedge clk) disable iff (rst)
    (start_i && len_code_i == 3'd7 && !order_i) |=> !last_o);

  assert_stop_ends_R8: assert property (@(posedge clk) disable iff (rst)
    (stop_i && !start_i) |=> (!valid_o && !last_o));

  assert_burst_continues_R3: assert property (@(posedge clk) disable iff (rst)
    (valid_o && !last_o && !stop_i) |=> valid_o);
endmodule

bind sdram_burst_colgen sdram_burst_colgen_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/sdram_burst_colgen_tb_top.sv
module sdram_burst_colgen_tb_top;
  localparam int unsigned COL_W = 10;

  typedef struct packed {
    logic [2:0]            code;
    logic                  ord;
    logic [COL_W-1:0]      col;
    logic [3:0]            len;
    logic [7:0][COL_W-1:0] exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{3'd3, 1'b0, 10'd90,   4'd8, {10'd89,10'd88,10'd95,10'd94,10'd93,10'd92,10'd91,10'd90}},
    '{3'd3, 1'b1, 10'd90,   4'd8, {10'd93,10'd92,10'd95,10'd94,10'd89,10'd88,10'd91,10'd90}},
    '{3'd2, 1'b0, 10'd311,  4'd4, {10'd0,10'd0,10'd0,10'd0,10'd310,10'd309,10'd308,10'd311}},
    '{3'd2, 1'b1, 10'd311,  4'd4, {10'd0,10'd0,10'd0,10'd0,10'd308,10'd309,10'd310,10'd311}},
    '{3'd1, 1'b0, 10'd1023, 4'd2, {10'd0,10'd0,10'd0,10'd0,10'd0,10'd0,10'd1022,10'd1023}},
    '{3'd1, 1'b1, 10'd1022, 4'd2, {10'd0,10'd0,10'd0,10'd0,10'd0,10'd0,10'd1023,10'd1022}},
    '{3'd0, 1'b0, 10'd500,  4'd1, {10'd0,10'd0,10'd0,10'd0,10'd0,10'd0,10'd0,10'd500}},
    '{3'd3, 1'b1, 10'd7,    4'd8, {10'd0,10'd1,10'd2,10'd3,10'd4,10'd5,10'd6,10'd7}},
    '{3'd5, 1'b0, 10'd77,   4'd1, {10'd0,10'd0,10'd0,10'd0,10'd0,10'd0,10'd0,10'd77}},
    '{3'd7, 1'b1, 10'd12,   4'd1, {10'd0,10'd0,10'd0,10'd0,10'd0,10'd0,10'd0,10'd12}},
    '{3'd3, 1'b0, 10'd1021, 4'd8, {10'd1020,10'd1019,10'd1018,10'd1017,10'd1016,10'd1023,10'd1022,10'd1021}}
  };

  logic             clk = 1'b0;
  logic             rst;
  logic             start_i;
  logic [COL_W-1:0] start_col_i;
  logic [2:0]       len_code_i;
  logic             order_i;
  logic             stop_i;
  logic [COL_W-1:0] col_o;
  logic             valid_o;
  logic             last_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sdram_burst_colgen #(.COL_W(COL_W)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .order_i(order_i), .stop_i(stop_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic beat(input string req, input int v, input int c, input int l);
    chk(req, "valid", int'(valid_o), v);
    if (v != 0) chk(req, "col", int'(col_o), c);
    chk(req, "last", int'(last_o), l);
  endtask

  task automatic go(input logic [2:0] code, input logic ord, input int col);
    start_i = 1'b1; len_code_i = code; order_i = ord; start_col_i = COL_W'(col);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  initial begin
    rst = 1'b1; start_i = 1'b0; stop_i = 1'b0;
    start_col_i = '0; len_code_i = '0; order_i = 1'b0;
    repeat (3) @(negedge clk);
    beat("R1", 0, 0, 0);
    chk("R1", "col at reset", int'(col_o), 0);
    rst = 1'b0;
    @(negedge clk);

    // R3 R4 R5 R6 R9: table walk
    for (int i = 0; i < NV; i++) begin
      go(VECS[i].code, VECS[i].ord, int'(VECS[i].col));
      for (int n = 0; n < int'(VECS[i].len); n++) begin
        beat(VECS[i].ord ? "R5" : "R4", 1, int'(VECS[i].exp[n]),
             (n == int'(VECS[i].len) - 1) ? 1 : 0);
        @(negedge clk);
      end
      beat("R3", 0, 0, 0);
      beat((VECS[i].code > 3'd3) ? "R9" : "R6", 0, 0, 0);
      @(negedge clk);
    end

    // R7: full page wraps past the top column
    go(3'd7, 1'b0, 1020);
    for (int n = 0; n < 1030; n++) begin
      beat("R7", 1, (1020 + n) % 1024, 0);
      @(negedge clk);
    end
    // R8: stop ends it
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    beat("R8", 0, 0, 0);
    @(negedge clk);
    beat("R8", 0, 0, 0);

    // R8: start wins over stop
    stop_i = 1'b1;
    go(3'd1, 1'b0, 40);
    stop_i = 1'b0;
    beat("R8", 1, 40, 0);
    @(negedge clk);
    beat("R8", 1, 41, 1);
    @(negedge clk);

    // R2: restart mid-burst
    go(3'd3, 1'b0, 0);
    beat("R2", 1, 0, 0);
    @(negedge clk);
    beat("R2", 1, 1, 0);
    go(3'd2, 1'b0, 42);
    beat("R2", 1, 42, 0);
    @(negedge clk);
    beat("R2", 1, 43, 0);
    @(negedge clk);
    beat("R2", 1, 40, 0);
    @(negedge clk);
    beat("R2", 1, 41, 1);
    @(negedge clk);
    beat("R2", 0, 0, 0);

    // R10: starts on consecutive clocks
    go(3'd3, 1'b1, 5);
    beat("R10", 1, 5, 0);
    go(3'd3, 1'b0, 100);
    beat("R10", 1, 100, 0);
    go(3'd0, 1'b0, 200);
    beat("R10", 1, 200, 1);
    @(negedge clk);
    beat("R10", 0, 0, 0);

    // R1: reset mid-burst
    go(3'd3, 1'b0, 300);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    beat("R1", 0, 0, 0);
    chk("R1", "col after reset", int'(col_o), 0);
    @(negedge clk);
    beat("R1", 0, 0, 0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (50000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule